// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Input Pull-Up Control

This block is an 8-bit general-purpose I/O port behind a small synchronous register interface. Three control registers are held: output data, direction and input pull-up control. A fourth address gives a read-only pin-state view. Each bit of that view shows the latched output data when the bit is an output, and the synchronised pad level when the bit is an input. The block drives a pad output enable and an output value for every bit. It also drives a pull-up enable for each bit, which is active only for an input bit whose pull-up control bit is set, and only if the operating mode allows that bit.

Two reset classes are separated. A power-on reset and a hardware standby request clear all three registers. A manual (warm) reset and a software standby request keep every register and the sampled pin levels frozen, and bus writes are ignored while either is active. Pad inputs pass through a two-flop synchroniser before they can be read.

Top module: `gpio_pullup_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the data, direction and pull-up registers become 0x00, so that all pads are inputs with no pull-up.
- R2: While `hw_stby` is high at a rising clock edge, the three registers are cleared to 0x00 in the same way as R1.
- R3: A write with `bus_we` high stores `bus_wdata` at the rising edge into the register chosen by `bus_addr` (0 = output data, 1 = direction, 3 = pull-up control), and the value reads back from the same address from the next cycle on.
- R4: A read at address 2 returns, for each bit, the output data bit when the direction bit is 1 and the synchronised pin level when the direction bit is 0.
- R5: A write to address 2 changes none of the three registers.
- R6: While `warm_rst_n` is low or `sw_stby` is high (and R1 and R2 do not apply), all registers and the sampled pin levels keep their values and writes are ignored.
- R7: `pad_oe` equals the direction register and `pad_out` equals the output data register.
- R8: `pad_pu_en` bit i is 1 only when direction bit i is 0 and pull-up bit i is 1 and the mode allows bit i: modes 6 and 7 allow all bits, modes 4 and 5 allow bits 7 to 5, every other mode allows none.
- R9: A change on `pad_in` that occurs after a rising edge appears in the address-2 read value after the second following rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; clears state |
| hw_stby | input | 1 | Hardware standby; clears state |
| warm_rst_n | input | 1 | Manual reset, active low; freezes state |
| sw_stby | input | 1 | Software standby; freezes state |
| op_mode | input | 3 | Operating mode, selects which pull-up bits may act |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu_en | output | 8 | Pad pull-up enables |

## Verification
The hardest situation to bring about is a frozen pin view: the pad levels have to change while a retaining state is active, and the read must still show the old sample. The bench gets there by settling a known level on the inputs, raising software standby or pulling the manual reset low, moving the pads to the complement, waiting several clocks, and reading address 2 before and after the freeze is released. Mixed direction patterns in the vector table check every bit of the pin-view mux and the mode gating at the same time.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: register addresses and widths.
package gpio_port_pkg;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA = 2'd0,
        ADR_DIR  = 2'd1,
        ADR_PIN  = 2'd2,
        ADR_PULL = 2'd3
    } gpio_addr_e;
endpackage

// File: rtl/gpio_ctl_reg.sv
// One control register of the port.
// Assumes: clear (power-on reset or hardware standby) wins over hold,
// and hold (manual reset or software standby) wins over a write.
module gpio_ctl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Register update: clear, then hold, then write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (!hold && wr_en)
            q <= wdata;
    end

    a_r2_clear_on_stby: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(q));
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold && !clr) |=> (q == $past(wdata)));
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the pad inputs, frozen while hold is active.
// Assumes: the pins are asynchronous; clear returns both stages to 0.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_q
);
    logic [W-1:0] stage1;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage1 <= '0;
            pin_q  <= '0;
        end else if (!hold) begin
            stage1 <= pin_i;
            pin_q  <= stage1;
        end
    end

    a_r9_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !clr) |=> (stage1 == $past(pin_i)));
    a_r6_sync_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(pin_q));
endmodule

// File: rtl/gpio_pull_gate.sv
// Pull-up enable gating by direction and operating mode.
// Assumes: modes FULL_LO..FULL_LO+1 allow all bits, NARROW_LO..NARROW_LO+1
// allow bits W-1 down to NARROW_BIT, all other modes allow none.
module gpio_pull_gate #(
    parameter int W          = 8,
    parameter int MODE_W     = 3,
    parameter int NARROW_LO  = 4,
    parameter int FULL_LO    = 6,
    parameter int NARROW_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      dir,
    input  logic [W-1:0]      pull,
    output logic [W-1:0]      pu_en
);
    localparam logic [W-1:0] FULL_MASK   = '1;
    localparam logic [W-1:0] NARROW_MASK = FULL_MASK << NARROW_BIT;

    logic [W-1:0] mode_mask;

    // Bits the current mode lets act.
    always_comb begin
        if (int'(mode) == FULL_LO || int'(mode) == FULL_LO + 1)
            mode_mask = FULL_MASK;
        else if (int'(mode) == NARROW_LO || int'(mode) == NARROW_LO + 1)
            mode_mask = NARROW_MASK;
        else
            mode_mask = '0;
    end

    // Per-bit pull-up enable.
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign pu_en[i] = !dir[i] && pull[i] && mode_mask[i];
        end
    endgenerate

    a_r8_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_en & dir) == '0));
    a_r8_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mode) < NARROW_LO || int'(mode) > FULL_LO + 1) |-> (pu_en == '0));
    a_r8_narrow_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mode) == NARROW_LO || int'(mode) == NARROW_LO + 1)
        |-> ((pu_en & ~NARROW_MASK) == '0));
endmodule

// File: rtl/gpio_pullup_port.sv
// Top of the GPIO port: register bank, input synchroniser, pin-state view
// and pull-up gating.
// Assumes: all control inputs are synchronous to clk; read data is
// combinational from bus_addr.
module gpio_pullup_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              warm_rst_n,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] op_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu_en
);
    localparam int NREG = 3;
    localparam gpio_addr_e REG_ADR [NREG] = '{ADR_DATA, ADR_DIR, ADR_PULL};

    logic         hold;
    logic [W-1:0] reg_q [NREG];
    logic [W-1:0] data_q, dir_q, pull_q, pin_q, pin_view;

    assign hold = !warm_rst_n || sw_stby;

    // One register per writable address.
    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            gpio_ctl_reg #(.W(W)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (hw_stby),
                .hold  (hold),
                .wr_en (bus_we && (bus_addr == REG_ADR[r])),
                .wdata (bus_wdata),
                .q     (reg_q[r])
            );
        end
    endgenerate

    assign data_q = reg_q[0];
    assign dir_q  = reg_q[1];
    assign pull_q = reg_q[2];

    gpio_in_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hw_stby),
        .hold  (hold),
        .pin_i (pad_in),
        .pin_q (pin_q)
    );

    gpio_pull_gate #(.W(W), .MODE_W(MODE_W)) u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (op_mode),
        .dir   (dir_q),
        .pull  (pull_q),
        .pu_en (pad_pu_en)
    );

    // Pin view: outputs show latched data, inputs show sampled level.
    assign pin_view = (dir_q & data_q) | (~dir_q & pin_q);

    // Read multiplexer by address.
    always_comb begin
        unique case (gpio_addr_e'(bus_addr))
            ADR_DATA: bus_rdata = data_q;
            ADR_DIR:  bus_rdata = dir_q;
            ADR_PIN:  bus_rdata = pin_view;
            ADR_PULL: bus_rdata = pull_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;

    a_r5_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_PIN && !hw_stby)
        |=> ($stable(data_q) && $stable(dir_q) && $stable(pull_q)));
    a_r1_por_clear: assert property (@(posedge clk) disable iff (!warm_rst_n)
        (!rst_n) |=> (pad_oe == '0 && pad_pu_en == '0));
endmodule

// File: tb/gpio_pullup_port_test.sv
module gpio_pullup_port_test;
    localparam int CLK_P = 10;

    logic       clk = 0, rst_n = 0, hw_stby = 0, warm_rst_n = 1, sw_stby = 0;
    logic [2:0] op_mode = 3'd7;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0, pad_in = 0;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu_en;
    int errors = 0, checks = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_pullup_port uut (.*);

    // fields: dir, data, pull, mode, pins, expected view, expected pull-up
    localparam int NV = 7;
    localparam logic [55:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'hFF, 8'd7, 8'hA5, 8'hA5, 8'hFF},
        {8'hFF, 8'h3C, 8'hFF, 8'd6, 8'h00, 8'h3C, 8'h00},
        {8'hF0, 8'hA0, 8'h0F, 8'd7, 8'h5A, 8'hAA, 8'h0F},
        {8'h0F, 8'h05, 8'hFF, 8'd4, 8'hC3, 8'hC5, 8'hE0},
        {8'h00, 8'h00, 8'hFF, 8'd5, 8'hFF, 8'hFF, 8'hE0},
        {8'h00, 8'h00, 8'hFF, 8'd2, 8'h00, 8'h00, 8'h00},
        {8'h81, 8'h80, 8'h7E, 8'd6, 8'h7F, 8'hFE, 8'h7E}
    };

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_clks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_P * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        wait_clks(3);
        // R1: reset state
        rd(0, v); check("R1 data", v, 8'h00);
        rd(1, v); check("R1 dir", v, 8'h00);
        rd(3, v); check("R1 pull", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        @(negedge clk); rst_n = 1;

        // R3 R4 R7 R8: vector table
        for (int k = 0; k < NV; k++) begin
            wr(1, VEC[k][55:48]);
            wr(0, VEC[k][47:40]);
            wr(3, VEC[k][39:32]);
            op_mode = VEC[k][26:24];
            pad_in  = VEC[k][23:16];
            wait_clks(3);
            rd(0, v); check("R3 data readback", v, VEC[k][47:40]);
            rd(3, v); check("R3 pull readback", v, VEC[k][39:32]);
            rd(2, v); check("R4 pin view", v, VEC[k][15:8]);
            check("R7 pad_oe", pad_oe, VEC[k][55:48]);
            check("R7 pad_out", pad_out, VEC[k][47:40]);
            check("R8 pull enable", pad_pu_en, VEC[k][7:0]);
        end

        // R5: write to pin address changes nothing
        wr(1, 8'h0F); wr(0, 8'h33); wr(3, 8'h55);
        wr(2, 8'hAA);
        rd(0, v); check("R5 data", v, 8'h33);
        rd(1, v); check("R5 dir", v, 8'h0F);
        rd(3, v); check("R5 pull", v, 8'h55);

        // R9: two-clock latency on pin view
        wr(1, 8'h00);
        pad_in = 8'h00; wait_clks(3);
        rd(2, v); check("R9 base", v, 8'h00);
        pad_in = 8'h96;
        @(negedge clk); #1 check("R9 after one edge", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R9 after two edges", bus_rdata, 8'h96);

        // R6: software standby freezes registers and pin view
        pad_in = 8'h11; wait_clks(3);
        @(negedge clk); sw_stby = 1;
        pad_in = 8'hEE;
        wr(0, 8'hFF); wr(3, 8'h00);
        wait_clks(3);
        rd(2, v); check("R6 stby pin view", v, 8'h11);
        rd(0, v); check("R6 stby data", v, 8'h33);
        rd(3, v); check("R6 stby pull", v, 8'h55);
        @(negedge clk); sw_stby = 0;
        wait_clks(3);
        rd(2, v); check("R6 stby release", v, 8'hEE);

        // R6: manual reset keeps state
        @(negedge clk); warm_rst_n = 0;
        pad_in = 8'h22;
        wr(1, 8'hFF);
        wait_clks(3);
        rd(1, v); check("R6 warm dir", v, 8'h00);
        rd(2, v); check("R6 warm pin view", v, 8'hEE);
        rd(3, v); check("R6 warm pull", v, 8'h55);
        @(negedge clk); warm_rst_n = 1;

        // R2: hardware standby clears
        wr(1, 8'hF0);
        @(negedge clk); hw_stby = 1;
        @(negedge clk); hw_stby = 0;
        rd(0, v); check("R2 data", v, 8'h00);
        rd(1, v); check("R2 dir", v, 8'h00);
        rd(3, v); check("R2 pull", v, 8'h00);
        check("R2 pu_en", pad_pu_en, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule